// File: doc/BRIEF.md
# Split-Transaction Bus Request Tracker

This block is the processor-side controller of a shared system bus. One set of 64 lines carries an address in one bus cycle and data in later cycles. A cache controller gives it two kinds of request: read misses and write-backs. The block queues them and gets the bus through an external arbiter. It gives each transaction it launches a small identifier, then drives the address cycle and, for a write-back, the data beats that follow.

Reads are split. The block drives only the read address. The system returns the data later, tagged with the read's identifier. The block looks the identifier up in its scoreboard of open transactions and passes the fill to the cache side together with the original address. No more than two reads may be open at a time. Write-backs hold an identifier until the system acknowledges them, so several write-backs can be in flight next to the reads.

The bus cycle lasts three core clocks. The block makes the one-in-three bus enable itself and presents it on a port. The request to the arbiter is raised while the current transaction is still moving data, so a grant that arrives early lets the next address cycle follow the last data beat directly.

Top module: `bt_bus_tracker`

## Requirements
- R1: `bus_tick_o` is high for exactly one core clock in every three. `bus_cmd_o`, `bus_out_o`, `bus_id_o`, `bus_oe_o` and `bus_req_o` change only on the clock edge that ends a tick cycle. The bus-side inputs are sampled only on that edge.
- R2: Requests are accepted when `req_valid_i` and `req_ready_o` are both high. The queue holds four requests; `req_ready_o` goes low while four are waiting. Requests go onto the bus in the order they were accepted.
- R3: No more than two reads are open at once. A read at the head of the queue while two are open waits there, and `bus_req_o` stays low, until one of the open reads returns its data.
- R4: Each launched transaction takes the lowest-numbered free identifier. An identifier is not given out again until it is released. When no identifier is free, nothing is launched and `bus_req_o` stays low.
- R5: A read takes one bus cycle with `bus_cmd_o` = 2'b01. `bus_out_o` carries the 32-bit address with zeros above it, and `bus_id_o` carries the identifier.
- R6: A write-back takes one address cycle with `bus_cmd_o` = 2'b10, followed directly by two data cycles with `bus_cmd_o` = 2'b11. The first data cycle carries `req_wdata_i[63:0]` and the second carries `req_wdata_i[127:64]`. All three cycles carry the same identifier. An idle bus cycle has `bus_cmd_o` = 2'b00 and `bus_oe_o` low. `bus_oe_o` is high in every other cycle.
- R7: A return (`rd_valid_i`) whose identifier belongs to an open read raises `fill_valid_o` for one core clock. The fill shows that identifier, the read's address and `rd_data_i`. The return frees both the read slot and the identifier.
- R8: A return whose identifier belongs to no open read sets `stray_err_o`. The flag stays set until reset. The return produces no fill and changes no open transaction.
- R9: `wb_ack_i` releases the identifier of an open write-back. An acknowledgement that names an identifier held by a read, or a free identifier, has no effect.
- R10: While a transaction is driving its data beats, the block raises `bus_req_o` if the next request could be launched. A grant taken during those beats makes the next address cycle follow the last beat with no idle cycle between. `bus_req_o` drops once a grant has been taken and stays low until that grant is used.
- R11: No address cycle is driven unless `bus_gnt_i` was high on a tick edge while `bus_req_o` was high. This applies to the edge that launches the transaction or any earlier tick edge since the last launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Cache-side request present |
| req_ready_o | output | 1 | Request queue can accept |
| req_wb_i | input | 1 | 1 = write-back, 0 = read miss |
| req_addr_i | input | 32 | Request address |
| req_wdata_i | input | 128 | Write-back data, beat 0 in the low 64 bits |
| bus_tick_o | output | 1 | Bus enable, high one core clock in three |
| bus_req_o | output | 1 | Request to the bus arbiter |
| bus_gnt_i | input | 1 | Grant from the bus arbiter |
| bus_out_o | output | 64 | Address or data driven on the shared lines |
| bus_oe_o | output | 1 | Output enable for the shared lines |
| bus_cmd_o | output | 2 | Bus cycle type: idle, read address, write-back address, write-back data |
| bus_id_o | output | 2 | Transaction identifier of the current cycle |
| rd_valid_i | input | 1 | Read data return present |
| rd_id_i | input | 2 | Identifier of the returning read |
| rd_data_i | input | 64 | Returned read data |
| wb_ack_i | input | 1 | Write-back acknowledgement present |
| wb_ack_id_i | input | 2 | Identifier of the acknowledged write-back |
| fill_valid_o | output | 1 | Matched read data to the cache, one core clock |
| fill_id_o | output | 2 | Identifier of the fill |
| fill_addr_o | output | 32 | Address of the read being filled |
| fill_data_o | output | 64 | Fill data |
| stray_err_o | output | 1 | Sticky flag for a return with no matching read |

## Verification
The bench uses the default parameters: four identifiers, two read slots, a four-entry queue and a divide-by-three bus enable. With only four identifiers, two write-backs and two reads use up the whole pool. That lets one test cover both stall causes, an exhausted identifier pool and a full set of read slots. With a four-entry queue, the full-queue back-pressure and the in-order launch of a mixed read and write-back sequence take only a few pushes. The two-beat write-back is long enough to show a grant taken during the data beats, and the next address cycle following the last beat with no idle cycle between.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int BT_BUS_W    = 64;
    localparam int BT_ADDR_W   = 32;
    localparam int BT_WB_BEATS = 2;

    typedef enum logic [1:0] {
        CMD_IDLE    = 2'b00,
        CMD_RD_ADDR = 2'b01,
        CMD_WB_ADDR = 2'b10,
        CMD_WB_DATA = 2'b11
    } bus_cmd_e;

    typedef struct packed {
        logic                                    is_wb;
        logic [BT_ADDR_W-1:0]                    addr;
        logic [BT_WB_BEATS-1:0][BT_BUS_W-1:0]    data;
    } bt_req_t;

endpackage

// File: rtl/bt_req_fifo.sv
module bt_req_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         valid_o,
    output logic         full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t q, d;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (push_i) begin
            d.mem[q.wp] = din_i;
            d.wp        = bump(q.wp);
        end
        if (pop_i) begin
            d.rp = bump(q.rp);
        end
        d.cnt = q.cnt + CNT_W'(push_i) - CNT_W'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout_o  = q.mem[q.rp];
    assign valid_o = (q.cnt != '0);
    assign full_o  = (q.cnt == CNT_W'(DEPTH));

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push_i |-> !full_o); // R2
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop_i |-> valid_o); // R2

endmodule

// File: rtl/bt_scoreboard.sv
module bt_scoreboard #(
    parameter int NUM_ID = 4,
    parameter int MAX_RD = 2,
    parameter int ADDR_W = 32,
    localparam int ID_W  = $clog2(NUM_ID),
    localparam int RDC_W = $clog2(NUM_ID + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic              alloc_rd_i,
    input  logic [ADDR_W-1:0] alloc_addr_i,
    input  logic              ret_valid_i,
    input  logic [ID_W-1:0]   ret_id_i,
    input  logic              ack_valid_i,
    input  logic [ID_W-1:0]   ack_id_i,
    output logic              free_any_o,
    output logic [ID_W-1:0]   free_id_o,
    output logic [RDC_W-1:0]  rd_open_o,
    output logic              hit_o,
    output logic [ADDR_W-1:0] hit_addr_o,
    output logic              err_o
);
    typedef struct packed {
        logic [NUM_ID-1:0]             busy;
        logic [NUM_ID-1:0]             rd;
        logic [NUM_ID-1:0][ADDR_W-1:0] addr;
        logic                          err;
    } sb_st_t;

    sb_st_t q, d;
    logic   ret_in_range, ack_in_range;

    always_comb begin
        free_any_o = 1'b0;
        free_id_o  = '0;
        for (int i = NUM_ID - 1; i >= 0; i--) begin
            if (!q.busy[i]) begin
                free_any_o = 1'b1;
                free_id_o  = ID_W'(i);
            end
        end
        rd_open_o = '0;
        for (int i = 0; i < NUM_ID; i++) begin
            rd_open_o = rd_open_o + RDC_W'(q.busy[i] & q.rd[i]);
        end
    end

    assign ret_in_range = ({1'b0, ret_id_i} < (ID_W + 1)'(NUM_ID));
    assign ack_in_range = ({1'b0, ack_id_i} < (ID_W + 1)'(NUM_ID));
    assign hit_o        = ret_valid_i && ret_in_range && q.busy[ret_id_i] && q.rd[ret_id_i];
    assign hit_addr_o   = q.addr[ret_id_i];
    assign err_o        = q.err;

    always_comb begin
        d = q;
        if (hit_o) begin
            d.busy[ret_id_i] = 1'b0;
        end else if (ret_valid_i) begin
            d.err = 1'b1;
        end
        if (ack_valid_i && ack_in_range && q.busy[ack_id_i] && !q.rd[ack_id_i]) begin
            d.busy[ack_id_i] = 1'b0;
        end
        if (alloc_i) begin
            d.busy[free_id_o] = 1'b1;
            d.rd[free_id_o]   = alloc_rd_i;
            d.addr[free_id_o] = alloc_addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_RD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) rd_open_o <= RDC_W'(MAX_RD)); // R3
    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n) alloc_i |-> free_any_o); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_o |=> err_o); // R8

endmodule

// File: rtl/bt_bus_seq.sv
module bt_bus_seq
    import bt_pkg::*;
#(
    parameter int NUM_ID = 4,
    localparam int ID_W   = $clog2(NUM_ID),
    localparam int BEAT_W = (BT_WB_BEATS > 1) ? $clog2(BT_WB_BEATS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  bt_req_t             head_i,
    input  logic                launch_ok_i,
    input  logic [ID_W-1:0]     free_id_i,
    input  logic                gnt_i,
    output logic                pop_o,
    output logic                alloc_o,
    output logic [BT_BUS_W-1:0] bus_out_o,
    output logic [1:0]          bus_cmd_o,
    output logic [ID_W-1:0]     bus_id_o,
    output logic                bus_req_o
);
    typedef struct packed {
        bus_cmd_e                             cmd;
        logic [BT_BUS_W-1:0]                  out;
        logic [ID_W-1:0]                      id;
        logic [BEAT_W-1:0]                    beat;
        logic [BT_WB_BEATS-1:0][BT_BUS_W-1:0] data;
        logic                                 hold;
        logic                                 req;
    } seq_st_t;

    seq_st_t q, d;
    logic    hold;

    always_comb begin
        d       = q;
        pop_o   = 1'b0;
        alloc_o = 1'b0;
        hold    = q.hold;
        if (tick_i) begin
            hold = q.hold | (q.req & gnt_i);
            if (q.cmd == CMD_WB_ADDR) begin
                d.cmd  = CMD_WB_DATA;
                d.beat = '0;
                d.out  = q.data[0];
            end else if (q.cmd == CMD_WB_DATA && q.beat != BEAT_W'(BT_WB_BEATS - 1)) begin
                d.beat = q.beat + 1'b1;
                d.out  = q.data[d.beat];
            end else if (hold && launch_ok_i) begin
                pop_o   = 1'b1;
                alloc_o = 1'b1;
                hold    = 1'b0;
                d.cmd   = head_i.is_wb ? CMD_WB_ADDR : CMD_RD_ADDR;
                d.out   = BT_BUS_W'(head_i.addr);
                d.id    = free_id_i;
                d.data  = head_i.data;
            end else begin
                d.cmd = CMD_IDLE;
                d.out = '0;
            end
            d.hold = hold;
            d.req  = launch_ok_i && !hold && !alloc_o;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_out_o = q.out;
    assign bus_cmd_o = q.cmd;
    assign bus_id_o  = q.id;
    assign bus_req_o = q.req;

    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !tick_i |=> $stable(bus_cmd_o)); // R1
    AST_REQ_DROPS_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n) q.hold |-> !bus_req_o); // R10
    AST_WB_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (tick_i && bus_cmd_o == CMD_WB_ADDR) |=> bus_cmd_o == CMD_WB_DATA); // R6

endmodule

// File: rtl/bt_bus_tracker.sv
module bt_bus_tracker
    import bt_pkg::*;
#(
    parameter int NUM_ID     = 4,
    parameter int MAX_RD     = 2,
    parameter int FIFO_DEPTH = 4,
    parameter int CLK_DIV    = 3,
    localparam int ID_W      = $clog2(NUM_ID),
    localparam int RDC_W     = $clog2(NUM_ID + 1),
    localparam int DIV_W     = $clog2(CLK_DIV),
    localparam int REQ_W     = $bits(bt_req_t)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid_i,
    output logic                              req_ready_o,
    input  logic                              req_wb_i,
    input  logic [BT_ADDR_W-1:0]              req_addr_i,
    input  logic [BT_WB_BEATS*BT_BUS_W-1:0]   req_wdata_i,
    output logic                              bus_tick_o,
    output logic                              bus_req_o,
    input  logic                              bus_gnt_i,
    output logic [BT_BUS_W-1:0]               bus_out_o,
    output logic                              bus_oe_o,
    output logic [1:0]                        bus_cmd_o,
    output logic [ID_W-1:0]                   bus_id_o,
    input  logic                              rd_valid_i,
    input  logic [ID_W-1:0]                   rd_id_i,
    input  logic [BT_BUS_W-1:0]               rd_data_i,
    input  logic                              wb_ack_i,
    input  logic [ID_W-1:0]                   wb_ack_id_i,
    output logic                              fill_valid_o,
    output logic [ID_W-1:0]                   fill_id_o,
    output logic [BT_ADDR_W-1:0]              fill_addr_o,
    output logic [BT_BUS_W-1:0]               fill_data_o,
    output logic                              stray_err_o
);
    typedef struct packed {
        logic [DIV_W-1:0]     div;
        logic                 fill_v;
        logic [ID_W-1:0]      fill_id;
        logic [BT_ADDR_W-1:0] fill_addr;
        logic [BT_BUS_W-1:0]  fill_data;
    } top_st_t;

    top_st_t q, d;

    logic                 tick;
    logic                 fifo_full, fifo_valid, fifo_push, pop, alloc;
    logic [REQ_W-1:0]     fifo_dout;
    bt_req_t              din, head;
    logic                 free_any, hit, launch_ok;
    logic [ID_W-1:0]      free_id;
    logic [RDC_W-1:0]     rd_open;
    logic [BT_ADDR_W-1:0] hit_addr;
    logic [1:0]           cmd;

    assign tick = (q.div == DIV_W'(CLK_DIV - 1));

    always_comb begin
        din.is_wb = req_wb_i;
        din.addr  = req_addr_i;
        din.data  = req_wdata_i;
    end

    assign fifo_push   = req_valid_i && !fifo_full;
    assign req_ready_o = !fifo_full;
    assign head        = bt_req_t'(fifo_dout);
    assign launch_ok   = fifo_valid && free_any && (head.is_wb || rd_open < RDC_W'(MAX_RD));

    bt_req_fifo #(.DEPTH(FIFO_DEPTH), .W(REQ_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (fifo_push),
        .din_i   (din),
        .pop_i   (pop),
        .dout_o  (fifo_dout),
        .valid_o (fifo_valid),
        .full_o  (fifo_full)
    );

    bt_scoreboard #(.NUM_ID(NUM_ID), .MAX_RD(MAX_RD), .ADDR_W(BT_ADDR_W)) u_sb (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_i      (alloc),
        .alloc_rd_i   (!head.is_wb),
        .alloc_addr_i (head.addr),
        .ret_valid_i  (rd_valid_i && tick),
        .ret_id_i     (rd_id_i),
        .ack_valid_i  (wb_ack_i && tick),
        .ack_id_i     (wb_ack_id_i),
        .free_any_o   (free_any),
        .free_id_o    (free_id),
        .rd_open_o    (rd_open),
        .hit_o        (hit),
        .hit_addr_o   (hit_addr),
        .err_o        (stray_err_o)
    );

    bt_bus_seq #(.NUM_ID(NUM_ID)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .head_i      (head),
        .launch_ok_i (launch_ok),
        .free_id_i   (free_id),
        .gnt_i       (bus_gnt_i),
        .pop_o       (pop),
        .alloc_o     (alloc),
        .bus_out_o   (bus_out_o),
        .bus_cmd_o   (cmd),
        .bus_id_o    (bus_id_o),
        .bus_req_o   (bus_req_o)
    );

    always_comb begin
        d        = q;
        d.div    = tick ? '0 : q.div + 1'b1;
        d.fill_v = tick && hit;
        if (tick && hit) begin
            d.fill_id   = rd_id_i;
            d.fill_addr = hit_addr;
            d.fill_data = rd_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_tick_o   = tick;
    assign bus_cmd_o    = cmd;
    assign bus_oe_o     = (cmd != CMD_IDLE);
    assign fill_valid_o = q.fill_v;
    assign fill_id_o    = q.fill_id;
    assign fill_addr_o  = q.fill_addr;
    assign fill_data_o  = q.fill_data;

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R1
    AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n) fill_valid_o |=> !fill_valid_o); // R7
    AST_POP_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n) pop |-> launch_ok); // R11

endmodule

// File: tb/tb_bt_bus_tracker.sv
module tb_bt_bus_tracker;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid_i = 1'b0;
    logic         req_ready_o;
    logic         req_wb_i = 1'b0;
    logic [31:0]  req_addr_i = '0;
    logic [127:0] req_wdata_i = '0;
    logic         bus_tick_o;
    logic         bus_req_o;
    logic         bus_gnt_i = 1'b0;
    logic [63:0]  bus_out_o;
    logic         bus_oe_o;
    logic [1:0]   bus_cmd_o;
    logic [1:0]   bus_id_o;
    logic         rd_valid_i = 1'b0;
    logic [1:0]   rd_id_i = '0;
    logic [63:0]  rd_data_i = '0;
    logic         wb_ack_i = 1'b0;
    logic [1:0]   wb_ack_id_i = '0;
    logic         fill_valid_o;
    logic [1:0]   fill_id_o;
    logic [31:0]  fill_addr_o;
    logic [63:0]  fill_data_o;
    logic         stray_err_o;

    bt_bus_tracker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_wb_i(req_wb_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .bus_tick_o(bus_tick_o), .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
        .bus_out_o(bus_out_o), .bus_oe_o(bus_oe_o), .bus_cmd_o(bus_cmd_o), .bus_id_o(bus_id_o),
        .rd_valid_i(rd_valid_i), .rd_id_i(rd_id_i), .rd_data_i(rd_data_i),
        .wb_ack_i(wb_ack_i), .wb_ack_id_i(wb_ack_id_i),
        .fill_valid_o(fill_valid_o), .fill_id_o(fill_id_o), .fill_addr_o(fill_addr_o),
        .fill_data_o(fill_data_o), .stray_err_o(stray_err_o)
    );

    always #10 clk = ~clk;

    localparam logic [1:0] C_IDLE = 2'b00, C_RD = 2'b01, C_WBA = 2'b10, C_WBD = 2'b11;

    int total = 0;
    int failed = 0;
    int cycles = 0;
    bit auto_gnt = 1'b0;

    logic [1:0]  ob_cmd;
    logic [63:0] ob_out;
    logic [1:0]  ob_id;
    logic        ob_oe, ob_req, ob_fv, ob_err;
    logic [1:0]  ob_fid;
    logic [31:0] ob_faddr;
    logic [63:0] ob_fdata;

    function automatic logic [63:0] beat(input logic [31:0] a, input int k);
        return {a, 32'h0000_BE00 + 32'(k)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit rv, input logic [1:0] rid, input logic [63:0] rdat,
                        input bit av, input logic [1:0] aid);
        @(negedge clk);
        while (!bus_tick_o) @(negedge clk);
        bus_gnt_i   = auto_gnt && bus_req_o;
        rd_valid_i  = rv;
        rd_id_i     = rid;
        rd_data_i   = rdat;
        wb_ack_i    = av;
        wb_ack_id_i = aid;
        @(negedge clk);
        ob_cmd = bus_cmd_o; ob_out = bus_out_o; ob_id = bus_id_o; ob_oe = bus_oe_o;
        ob_req = bus_req_o; ob_fv = fill_valid_o; ob_fid = fill_id_o;
        ob_faddr = fill_addr_o; ob_fdata = fill_data_o; ob_err = stray_err_o;
        bus_gnt_i = 1'b0; rd_valid_i = 1'b0; wb_ack_i = 1'b0;
    endtask

    task automatic push(input bit wb, input logic [31:0] a, input string req);
        @(negedge clk);
        chk(req_ready_o == 1'b1, req, "ready before push", 64'(req_ready_o), 64'd1);
        req_valid_i = 1'b1;
        req_wb_i    = wb;
        req_addr_i  = a;
        req_wdata_i = {beat(a, 1), beat(a, 0)};
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    task automatic expect_cycle(input logic [1:0] ecmd, input logic [63:0] eout,
                                input logic [1:0] eid, input string req);
        chk(ob_cmd == ecmd, req, "bus_cmd", 64'(ob_cmd), 64'(ecmd));
        chk(ob_out == eout && ob_id == eid && ob_oe, req, "bus_out/id/oe",
            {ob_out[61:0], ob_id}, {eout[61:0], eid});
    endtask

    task automatic wait_cmd(input logic [1:0] ecmd, input logic [63:0] eout,
                            input logic [1:0] eid, input string req);
        for (int i = 0; i < 12; i++) begin
            step(0, 0, 0, 0, 0);
            if (ob_cmd != C_IDLE) break;
        end
        expect_cycle(ecmd, eout, eid, req);
    endtask

    task automatic idle_steps(input int n, input bit ereq, input string req);
        for (int i = 0; i < n; i++) begin
            step(0, 0, 0, 0, 0);
            chk(ob_cmd == C_IDLE && !ob_oe, req, "bus idle", 64'(ob_cmd), 64'(C_IDLE));
            chk(ob_req == ereq, req, "bus_req", 64'(ob_req), 64'(ereq));
        end
    endtask

    task automatic ret(input logic [1:0] id, input logic [63:0] dat,
                       input logic [31:0] eaddr, input string req);
        step(1, id, dat, 0, 0);
        chk(ob_fv == 1'b1, req, "fill_valid", 64'(ob_fv), 64'd1);
        chk(ob_fid == id && ob_faddr == eaddr, req, "fill id/addr",
            {30'd0, ob_fid, ob_faddr}, {30'd0, id, eaddr});
        chk(ob_fdata == dat, req, "fill_data", ob_fdata, dat);
    endtask

    task automatic ack(input logic [1:0] id);
        step(0, 0, 0, 1, id);
    endtask

    task automatic t_reset;
        chk(bus_cmd_o == C_IDLE && !bus_oe_o, "R6", "reset idle", 64'(bus_cmd_o), 64'd0);
        chk(req_ready_o == 1'b1, "R2", "reset ready", 64'(req_ready_o), 64'd1);
        chk(!bus_req_o && !fill_valid_o && !stray_err_o, "R8", "reset flags",
            {61'd0, bus_req_o, fill_valid_o, stray_err_o}, 64'd0);
    endtask

    task automatic t_tick;
        int hi = 0;
        bit prev = 1'b0, dbl = 1'b0;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            if (bus_tick_o) hi++;
            if (bus_tick_o && prev) dbl = 1'b1;
            prev = bus_tick_o;
        end
        chk(hi == 3 && !dbl, "R1", "tick one in three", 64'(hi), 64'd3);
    endtask

    // R2 order and back-pressure, R11 no launch without grant, R4/R5/R6 cycle content
    task automatic t_queue_order;
        auto_gnt = 1'b0;
        push(1, 32'h500, "R2");
        push(0, 32'h600, "R2");
        push(1, 32'h700, "R2");
        push(0, 32'h800, "R2");
        chk(req_ready_o == 1'b0, "R2", "ready low when four queued", 64'(req_ready_o), 64'd0);
        idle_steps(3, 1'b1, "R11");
        auto_gnt = 1'b1;
        wait_cmd(C_WBA, 64'h500, 2'd0, "R6");
        wait_cmd(C_WBD, beat(32'h500, 0), 2'd0, "R6");
        wait_cmd(C_WBD, beat(32'h500, 1), 2'd0, "R6");
        wait_cmd(C_RD, 64'h600, 2'd1, "R5");
        wait_cmd(C_WBA, 64'h700, 2'd2, "R4");
        wait_cmd(C_WBD, beat(32'h700, 0), 2'd2, "R6");
        wait_cmd(C_WBD, beat(32'h700, 1), 2'd2, "R6");
        wait_cmd(C_RD, 64'h800, 2'd3, "R2");
    endtask

    // R4 pool exhaustion, R9 acknowledgement release and ignored acknowledgement
    task automatic t_id_pool;
        push(1, 32'h900, "R4");
        idle_steps(3, 1'b0, "R4");
        ack(2'd1);
        idle_steps(3, 1'b0, "R9");
        ack(2'd2);
        wait_cmd(C_WBA, 64'h900, 2'd2, "R9");
        wait_cmd(C_WBD, beat(32'h900, 0), 2'd2, "R6");
        wait_cmd(C_WBD, beat(32'h900, 1), 2'd2, "R6");
        ack(2'd0);
        ack(2'd2);
        ret(2'd1, 64'h1111_2222_3333_4444, 32'h600, "R9");
        ret(2'd3, 64'h5555_6666_7777_8888, 32'h800, "R7");
    endtask

    // R3 read slot limit, R7 matching, R8 unmatched return
    task automatic t_read_limit;
        chk(stray_err_o == 1'b0, "R8", "flag clear before stray", 64'(stray_err_o), 64'd0);
        push(0, 32'hA00, "R3");
        push(0, 32'hA40, "R3");
        push(0, 32'hA80, "R3");
        wait_cmd(C_RD, 64'hA00, 2'd0, "R3");
        wait_cmd(C_RD, 64'hA40, 2'd1, "R3");
        idle_steps(4, 1'b0, "R3");
        ret(2'd1, 64'hCAFE_0000_0000_0041, 32'hA40, "R7");
        wait_cmd(C_RD, 64'hA80, 2'd1, "R3");
        step(1, 2'd3, 64'hDEAD, 0, 0);
        chk(ob_fv == 1'b0, "R8", "no fill on stray", 64'(ob_fv), 64'd0);
        chk(ob_err == 1'b1, "R8", "stray flag", 64'(ob_err), 64'd1);
        ret(2'd0, 64'hCAFE_0000_0000_0A00, 32'hA00, "R8");
        ret(2'd1, 64'hCAFE_0000_0000_0A80, 32'hA80, "R7");
        step(0, 0, 0, 0, 0);
        chk(ob_err == 1'b1, "R8", "flag sticky", 64'(ob_err), 64'd1);
    endtask

    // R10 arbitration overlapped with data beats
    task automatic t_overlap;
        push(1, 32'hB00, "R10");
        push(1, 32'hB80, "R10");
        wait_cmd(C_WBA, 64'hB00, 2'd0, "R10");
        step(0, 0, 0, 0, 0);
        expect_cycle(C_WBD, beat(32'hB00, 0), 2'd0, "R10");
        chk(ob_req == 1'b1, "R10", "req during beats", 64'(ob_req), 64'd1);
        step(0, 0, 0, 0, 0);
        expect_cycle(C_WBD, beat(32'hB00, 1), 2'd0, "R10");
        chk(ob_req == 1'b0, "R10", "req dropped after grant", 64'(ob_req), 64'd0);
        step(0, 0, 0, 0, 0);
        expect_cycle(C_WBA, 64'hB80, 2'd1, "R10");
        step(0, 0, 0, 0, 0);
        expect_cycle(C_WBD, beat(32'hB80, 0), 2'd1, "R6");
        step(0, 0, 0, 0, 0);
        expect_cycle(C_WBD, beat(32'hB80, 1), 2'd1, "R6");
        ack(2'd0);
        ack(2'd1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failed++;
            total++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tick();
        t_queue_order();
        t_id_pool();
        t_read_limit();
        t_overlap();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule